// File: doc/BRIEF.md
# Receive Descriptor Writeback Engine

This block keeps one receive descriptor ring in a small local store and completes one descriptor per incoming frame. Software sets the ring size in bytes and the receive buffer size in kilobytes, fills in the buffer address words of each descriptor, and moves the tail index forward to hand descriptors to the engine. It then sets the global receive enable and the queue enable.

When a frame is offered on the frame port, the engine takes the descriptor at the head index. It writes back the length, the checksum, the VLAN tag, a status byte and an error byte, and then steps the head forward. Each accepted frame uses exactly one descriptor. A frame longer than the buffer is recorded with the buffer size as its length and is flagged with an error. If the head equals the tail, no descriptor is free: the frame is dropped and a missed-frame counter counts it. Software reads the descriptors and the registers back through the same register port. Payload movement is not part of this block.

Top module: `rx_desc_wb`

## Requirements
- R1: After reset, the head, tail, missed count, ring size, buffer size, receive enable and queue enable all read 0, and `fr_ready` is 0.
- R2: Writing 1 to bit 25 of the queue control register (address 1) is not visible in that bit until one clock edge after the edge that performed the write.
- R3: `fr_ready` is 1 only while bit 0 of the receive control register (address 0) is 1 and the queue enable reads back 1. An offered frame that is not accepted changes neither the head nor the missed count.
- R4: An accepted frame with a free descriptor writes descriptor word 2 as {checksum[31:16], length[15:0]}. It writes word 3 as {vlan[31:16], error[15:8], status[7:0]}, where status bit 0 (done) and bit 1 (end of packet) are 1, bit 2 is 0, and bits 7:3 carry `fr_flags`. Words 0 and 1 (the buffer address) are left unchanged.
- R5: After each writeback, the head becomes (head + 1) modulo the descriptor count, where the descriptor count is the ring size register (address 2, bytes) divided by 16.
- R6: A frame accepted while head equals tail is dropped. The descriptor store and the head are left unchanged, and the missed count (address 6) increases by one.
- R7: If the frame length exceeds the buffer size (address 3, in units of 1024 bytes), the written length equals the buffer size and error bit 0 is 1. Otherwise the length is written unchanged and the error byte is 0.
- R8: The ring size, buffer size, head (address 4) and tail (address 5) registers can be written and read back. Descriptor word w of entry i is at address 64 + 4*i + w.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | IW+3 | Register or descriptor word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| fr_valid | input | 1 | A frame summary is offered |
| fr_ready | output | 1 | The engine takes the offered frame on this edge |
| fr_len | input | 16 | Frame length in bytes |
| fr_csum | input | 16 | Frame checksum |
| fr_flags | input | 5 | Status flags for bits 7:3 (IP, L4, UDP checksum, VLAN match, exact filter) |
| fr_vlan | input | 16 | VLAN tag |

## Verification
Every frame outcome (descriptor words, head step, missed count) lands on the clock edge that accepts the frame. The bench drives a frame at a falling edge and reads the results at the next falling edge through the combinational read port. Register writes follow the same pattern, except the queue enable, which is due one edge later. The bench reads it both at the first falling edge after the write, where it must still be 0, and again one cycle on. Random frames and tail moves are compared against a bench ring model, and directed cases hit the exact buffer boundary, ring wrap and the empty ring.

// File: rtl/rx_desc_wb.sv
module rx_desc_wb #(
  parameter int MAX_DESC = 16,
  parameter int BUFKB_W  = 6,
  localparam int IW      = $clog2(MAX_DESC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [IW+2:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          fr_valid,
  output logic          fr_ready,
  input  logic [15:0]   fr_len,
  input  logic [15:0]   fr_csum,
  input  logic [4:0]    fr_flags,
  input  logic [15:0]   fr_vlan
);
  localparam int NW = IW + 1;

  logic               rx_en, q_req, q_on;
  logic [NW-1:0]      ndesc;
  logic [BUFKB_W-1:0] buf_kb;
  logic [IW-1:0]      head, tail;
  logic [31:0]        missed;
  logic [127:0]       ring [MAX_DESC];

  wire                desc_sel = reg_addr[IW+2];
  wire [IW-1:0]       r_idx    = reg_addr[IW+1:2];
  wire [1:0]          r_word   = reg_addr[1:0];
  wire [2:0]          r_reg    = reg_addr[2:0];

  wire                take     = fr_valid & fr_ready;
  wire                empty    = head == tail;
  wire [NW-1:0]       head_inc = {1'b0, head} + NW'(1);
  wire [IW-1:0]       head_nxt = (head_inc == ndesc) ? '0 : head_inc[IW-1:0];
  wire [BUFKB_W+9:0]  buf_bytes = {buf_kb, 10'd0};
  wire                too_long = 32'(fr_len) > 32'(buf_bytes);
  wire [15:0]         wb_len   = too_long ? 16'(buf_bytes) : fr_len;
  wire [7:0]          wb_stat  = {fr_flags, 3'b011};
  wire [7:0]          wb_err   = {7'd0, too_long};

  assign fr_ready = rx_en & q_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_en  <= 1'b0;
      q_req  <= 1'b0;
      q_on   <= 1'b0;
      ndesc  <= '0;
      buf_kb <= '0;
      head   <= '0;
      tail   <= '0;
      missed <= '0;
      for (int i = 0; i < MAX_DESC; i++) ring[i] <= '0;
    end else begin
      q_on <= q_req;
      if (reg_we && !desc_sel) begin
        case (r_reg)
          3'd0: rx_en  <= reg_wdata[0];
          3'd1: q_req  <= reg_wdata[25];
          3'd2: ndesc  <= reg_wdata[IW+4:4];
          3'd3: buf_kb <= reg_wdata[BUFKB_W-1:0];
          3'd4: head   <= reg_wdata[IW-1:0];
          3'd5: tail   <= reg_wdata[IW-1:0];
          default: ;
        endcase
      end
      if (reg_we && desc_sel) ring[r_idx][r_word*32 +: 32] <= reg_wdata;
      if (take) begin
        if (empty) missed <= missed + 32'd1;
        else begin
          ring[head][127:64] <= {fr_vlan, wb_err, wb_stat, fr_csum, wb_len};
          head <= head_nxt;
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (desc_sel) reg_rdata = ring[r_idx][r_word*32 +: 32];
    else begin
      case (r_reg)
        3'd0: reg_rdata[0]            = rx_en;
        3'd1: reg_rdata[25]           = q_on;
        3'd2: reg_rdata[IW+4:4]       = ndesc;
        3'd3: reg_rdata[BUFKB_W-1:0]  = buf_kb;
        3'd4: reg_rdata[IW-1:0]       = head;
        3'd5: reg_rdata[IW-1:0]       = tail;
        3'd6: reg_rdata               = missed;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rx_desc_wb_chk.sv
module rx_desc_wb_chk #(
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic          fr_valid,
  input logic          fr_ready,
  input logic          q_req,
  input logic          q_on,
  input logic [IW-1:0] head,
  input logic [IW-1:0] tail,
  input logic [IW:0]   ndesc,
  input logic [31:0]   missed
);
  logic [IW:0] inc;
  assign inc = {1'b0, head} + (IW+1)'(1);

  a_r2_queue_lag: assert property (@(posedge clk) disable iff (!rst_n)
    q_on |-> $past(q_req));

  a_r3_refused_frame_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_valid && !fr_ready && !reg_we) |=> ($stable(head) && $stable(missed)));

  a_r5_head_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_valid && fr_ready && head != tail) |=>
      (head == (($past(inc) == $past(ndesc)) ? '0 : $past(inc[IW-1:0]))));

  a_r6_drop_count: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_valid && fr_ready && head == tail && !reg_we) |=>
      (missed == $past(missed) + 32'd1 && $stable(head)));
endmodule

bind rx_desc_wb rx_desc_wb_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .fr_valid(fr_valid),
  .fr_ready(fr_ready), .q_req(q_req), .q_on(q_on), .head(head),
  .tail(tail), .ndesc(ndesc), .missed(missed)
);

// File: tb/sim_rx_desc_wb.sv
`timescale 1ns/1ps
module sim_rx_desc_wb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        fr_valid = 1'b0, fr_ready;
  logic [15:0] fr_len = '0, fr_csum = '0, fr_vlan = '0;
  logic [4:0]  fr_flags = '0;

  int vecs = 0, fails = 0;
  logic [31:0] mw [16][4];
  int m_head = 0, m_tail = 0, m_nd = 0, m_kb = 0, m_missed = 0;
  bit m_en = 0;

  rx_desc_wb u0 (.*);

  always #4 clk = ~clk;

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  function automatic logic [31:0] exp_w2(int len, logic [15:0] cs, int kb);
    int b = kb * 1024;
    return {cs, 16'(len > b ? b : len)};
  endfunction

  function automatic logic [31:0] exp_w3(int len, logic [4:0] fl, logic [15:0] vl, int kb);
    return {vl, 7'd0, 1'(len > kb * 1024), fl, 3'b011};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 7'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = 7'(a);
    #1;
    d = reg_rdata;
  endtask

  task automatic send(input int len, input logic [15:0] cs, input logic [4:0] fl, input logic [15:0] vl);
    @(negedge clk);
    fr_valid = 1'b1; fr_len = 16'(len); fr_csum = cs; fr_flags = fl; fr_vlan = vl;
    @(negedge clk);
    fr_valid = 1'b0;
    if (m_en) begin
      if (m_head == m_tail) m_missed++;
      else begin
        mw[m_head][2] = exp_w2(len, cs, m_kb);
        mw[m_head][3] = exp_w3(len, fl, vl, m_kb);
        m_head = (m_head + 1) % m_nd;
      end
    end
  endtask

  task automatic verify(input int idx, input string tag);
    logic [31:0] d;
    for (int w = 0; w < 4; w++) begin
      rd(64 + idx * 4 + w, d);
      chk(tag, d, mw[idx][w]);
    end
    rd(4, d); chk({tag, " head R5"}, d, 32'(m_head));
    rd(6, d); chk({tag, " missed R6"}, d, 32'(m_missed));
  endtask

  initial begin
    logic [31:0] d;
    int idx;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) for (int w = 0; w < 4; w++) mw[i][w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int a = 0; a < 7; a++) begin rd(a, d); chk("R1 reset reg", d, 0); end
    chk("R1 reset ready", 32'(fr_ready), 0);

    wr(2, 8 * 16); m_nd = 8;
    wr(3, 1);      m_kb = 1;
    rd(2, d); chk("R8 ring size", d, 128);
    rd(3, d); chk("R8 buffer size", d, 1);
    for (int i = 0; i < 8; i++) begin
      mw[i][0] = 32'h1000_0000 + i * 32'h400; mw[i][1] = 32'(i);
      wr(64 + i * 4, mw[i][0]);
      wr(65 + i * 4, mw[i][1]);
    end
    rd(64 + 12, d); chk("R8 desc word", d, mw[3][0]);

    wr(0, 1);
    chk("R3 ready needs queue", 32'(fr_ready), 0);
    wr(1, 32'h0200_0000);
    rd(1, d); chk("R2 queue lag", d, 0);
    @(negedge clk);
    rd(1, d); chk("R2 queue on", d, 32'h0200_0000);
    chk("R3 ready on", 32'(fr_ready), 1);
    m_en = 1;

    send(100, 16'hbeef, 5'h1f, 16'h0123);
    verify(0, "R6 empty drop");

    wr(5, 5); m_tail = 5;
    rd(5, d); chk("R8 tail", d, 5);
    idx = m_head; send(1024, 16'h1111, 5'h05, 16'h0007); verify(idx, "R4 R7 exact fit");
    idx = m_head; send(1025, 16'h2222, 5'h12, 16'h0008); verify(idx, "R7 truncate");

    for (int k = 0; k < 80; k++) begin
      if ($urandom_range(0, 2) == 0) begin
        m_tail = $urandom_range(0, m_nd - 1);
        wr(5, m_tail);
      end
      idx = m_head;
      send($urandom_range(60, 1500), 16'($urandom), 5'($urandom), 16'($urandom));
      verify(idx, "R4 R5 random");
    end

    wr(2, 5 * 16); m_nd = 5;
    wr(4, 3); m_head = 3;
    wr(5, 1); m_tail = 1;
    idx = 3; send(200, 16'h3333, 5'h01, 16'h0001); verify(idx, "R5 before wrap");
    idx = 4; send(201, 16'h4444, 5'h02, 16'h0002); verify(idx, "R5 wrap");
    chk("R5 wrapped to zero", 32'(m_head), 0);

    wr(3, 2); m_kb = 2;
    idx = m_head; send(2048, 16'h5555, 5'h03, 16'h0003); verify(idx, "R7 2k fit");
    idx = m_head; send(2049, 16'h6666, 5'h04, 16'h0004); verify(idx, "R6 R7 2k full");

    wr(0, 0); m_en = 0;
    chk("R3 ready off", 32'(fr_ready), 0);
    idx = m_head; send(300, 16'h7777, 5'h08, 16'h0005); verify(idx, "R3 refused");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule